// File: doc/BRIEF.md
# Receive Descriptor Ring Poller

This block keeps track of which receive descriptors in a host-memory ring the device currently owns, and it moves through that ring as frames arrive. It reads the ownership bit of the current descriptor and, once that one is held, of the following descriptor. It re-reads them when the host asks, when receive data is waiting for a buffer, or on a programmed interval. It stays silent while it already holds both. When a frame spills over a buffer, and again when a frame completes, it writes the current descriptor back and steps the ring index forward.

The descriptor port carries a request with a read/write flag and an address (`ring_base + 16 * index`), and a write carries the writeback fields. The responder raises `desc_ack` once to complete each request, and returns the ownership bit with it on reads. Upstream logic reports buffer-full and frame-end events as one-cycle pulses, together with a running byte count, an error flag and receive-overflow pulses.

States: `ST_IDLE` (waits for an event), `ST_RD_CUR` (reads the current descriptor), `ST_RD_NXT` (reads the next descriptor), `ST_WR_SPILL` (writes back a filled buffer), `ST_WR_LAST` (writes back the frame status). Transitions: IDLE to WR_LAST on frame end while the current descriptor is held. Otherwise IDLE to WR_SPILL on buffer full while it is held. Otherwise, on a poll trigger, IDLE goes to RD_CUR if the current descriptor is not held and to RD_NXT if it is. RD_CUR goes to RD_NXT on an acknowledge that reports ownership when the ring is longer than one, and to IDLE on any other acknowledge. RD_NXT, WR_SPILL and WR_LAST go to IDLE on acknowledge.

Top module: `rx_desc_poller`

## Requirements
- R1: A poll reads the current descriptor at `ring_base + 16*cur_idx`. When that read reports OWN=1 and `ring_len` > 1, the poll then reads the next descriptor at `ring_base + 16*((cur_idx+1) mod ring_len)`. With `ring_len` = 1 only the current descriptor is read.
- R2: While both the current and the next descriptor are held (for `ring_len` = 1, the current one alone), no read is issued: the interval timer and `poll_demand` have no effect.
- R3: When `data_waiting` is high and the current descriptor is not held, a read starts in the cycle after. If that read returns OWN=0, the next read waits for the interval timer.
- R4: A `poll_demand` pulse while not holding both descriptors starts a read in the following cycle.
- R5: While idle and not holding both descriptors, consecutive polls of an unowned current descriptor start exactly `poll_ivl + 2` cycles apart.
- R6: A `buf_full` pulse while the current descriptor is held writes that descriptor with OWN=0 and ENP=0, with STP=1 only on the first buffer of a frame. The ring index then advances.
- R7: A `frame_end` pulse while the current descriptor is held writes OWN=0, ENP=1, the byte count and the error flag, with STP=1 only when the frame used a single buffer. The ring index then advances.
- R8: The ring index wraps to 0 after `ring_len - 1` and never reaches `ring_len`.
- R9: An `fifo_ovf` pulse while the current descriptor is not held raises `miss_cnt` by one in the next cycle. While the descriptor is held, `miss_cnt` does not change.
- R10: `frame_notify` pulses for one cycle, one cycle after `byte_cnt` first reaches PROTECT (default 64). It does not pulse again until `byte_cnt` drops below PROTECT.
- R11: A request keeps its address and read/write flag stable until the cycle in which `desc_ack` is high.
- R12: During reset, `desc_req`, `frame_notify`, `cur_idx` and `miss_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| ring_len | input | IDX_W+1 | Number of descriptors in the ring (1 or more) |
| poll_ivl | input | IVL_W | Idle cycles between interval polls |
| poll_demand | input | 1 | Pulse that requests an immediate poll |
| data_waiting | input | 1 | Receive FIFO holds data for a buffer |
| buf_full | input | 1 | Pulse: current buffer filled, frame continues |
| frame_end | input | 1 | Pulse: last byte of the frame has left the FIFO |
| frame_err | input | 1 | Error flag of the ending frame |
| byte_cnt | input | BC_W | Bytes received in the current frame |
| fifo_ovf | input | 1 | Pulse: receive FIFO overflowed |
| desc_req | output | 1 | Descriptor access request |
| desc_we | output | 1 | 1 = writeback, 0 = ownership read |
| desc_addr | output | AW | Descriptor byte address |
| desc_wr_own | output | 1 | Ownership value written (always 0) |
| desc_wr_enp | output | 1 | End-of-packet value written |
| desc_wr_stp | output | 1 | Start-of-packet value written |
| desc_wr_bcnt | output | BC_W | Byte count written |
| desc_wr_err | output | 1 | Error flag written |
| desc_ack | input | 1 | Request completes in this cycle |
| desc_rd_own | input | 1 | Ownership bit returned with a read acknowledge |
| cur_idx | output | IDX_W | Current ring index |
| frame_notify | output | 1 | Protect count reached for this frame |
| miss_cnt | output | MISS_W | Frames dropped for lack of a descriptor |

## Verification
A poll trigger applied just after a clock edge produces a request one edge later. The bench therefore counts request starts in the next cycle for R3 and R4. It measures the start-to-start spacing against `poll_ivl + 2` for the interval polls of R5. `miss_cnt` and `frame_notify` are registered, so both are sampled exactly one cycle after their input pulse. For writebacks, the bench waits for the write to reach its memory model and checks the captured fields against its own running ring index. A responder with a configurable acknowledge delay confirms that each request stays stable until it is answered.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_CUR   = 3'd1,
        ST_RD_NXT   = 3'd2,
        ST_WR_SPILL = 3'd3,
        ST_WR_LAST  = 3'd4
    } rxp_state_e;

endpackage

// File: rtl/rxp_poll_timer.sv
module rxp_poll_timer #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [IVL_W-1:0] ivl,
    output logic             hit
);

    logic [IVL_W-1:0] cnt_q;

    assign hit = (cnt_q == ivl);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rxp_ring_index.sv
module rxp_ring_index #(
    parameter int IDX_W      = 4,
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W:0]   ring_len,
    input  logic [AW-1:0]    ring_base,
    output logic [IDX_W-1:0] nxt_idx,
    output logic [AW-1:0]    cur_addr,
    output logic [AW-1:0]    nxt_addr
);

    localparam int OFS_SH = $clog2(DESC_BYTES);

    logic [IDX_W:0] inc;

    assign inc     = {1'b0, cur_idx} + 1'b1;
    assign nxt_idx = (inc >= ring_len) ? '0 : inc[IDX_W-1:0];

    assign cur_addr = ring_base + ({{(AW-IDX_W){1'b0}}, cur_idx} << OFS_SH);
    assign nxt_addr = ring_base + ({{(AW-IDX_W){1'b0}}, nxt_idx} << OFS_SH);

endmodule

// File: rtl/rxp_protect.sv
module rxp_protect #(
    parameter int BC_W    = 12,
    parameter int PROTECT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BC_W-1:0] byte_cnt,
    output logic            notify
);

    logic reached, seen_q;

    assign reached = (byte_cnt >= BC_W'(PROTECT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            notify <= 1'b0;
        end else begin
            seen_q <= reached;
            notify <= reached && !seen_q;
        end
    end

endmodule

// File: rtl/rx_desc_poller.sv
module rx_desc_poller
    import rxp_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int AW         = 32,
    parameter int IVL_W      = 8,
    parameter int BC_W       = 12,
    parameter int MISS_W     = 8,
    parameter int DESC_BYTES = 16,
    parameter int PROTECT    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ring_base,
    input  logic [IDX_W:0]    ring_len,
    input  logic [IVL_W-1:0]  poll_ivl,
    input  logic              poll_demand,
    input  logic              data_waiting,
    input  logic              buf_full,
    input  logic              frame_end,
    input  logic              frame_err,
    input  logic [BC_W-1:0]   byte_cnt,
    input  logic              fifo_ovf,
    output logic              desc_req,
    output logic              desc_we,
    output logic [AW-1:0]     desc_addr,
    output logic              desc_wr_own,
    output logic              desc_wr_enp,
    output logic              desc_wr_stp,
    output logic [BC_W-1:0]   desc_wr_bcnt,
    output logic              desc_wr_err,
    input  logic              desc_ack,
    input  logic              desc_rd_own,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              frame_notify,
    output logic [MISS_W-1:0] miss_cnt
);

    localparam logic [IDX_W:0] LEN_ONE = {{IDX_W{1'b0}}, 1'b1};

    rxp_state_e        state_q, state_d;
    logic              own_cur, own_nxt, in_frame, dry, dmd_pend;
    logic [IDX_W-1:0]  idx_q, nxt_idx;
    logic [AW-1:0]     cur_addr, nxt_addr;
    logic [BC_W-1:0]   bcnt_q;
    logic              err_q;
    logic [MISS_W-1:0] miss_q;
    logic              both_owned, imm_poll, poll_go, ack_take;
    logic              timer_hit, timer_run, poll_start, advance, take_last;

    assign both_owned = own_cur && (own_nxt || ring_len == LEN_ONE);
    assign imm_poll   = data_waiting && !own_cur && !dry;
    assign poll_go    = !both_owned && (timer_hit || dmd_pend || poll_demand || imm_poll);
    assign ack_take   = (state_q != ST_IDLE) && desc_ack;
    assign timer_run  = (state_q == ST_IDLE) && !both_owned;
    assign poll_start = (state_q == ST_IDLE) &&
                        (state_d == ST_RD_CUR || state_d == ST_RD_NXT);
    assign advance    = ack_take && (state_q == ST_WR_SPILL || state_q == ST_WR_LAST);
    assign take_last  = (state_q == ST_IDLE) && own_cur && frame_end;

    rxp_ring_index #(
        .IDX_W      (IDX_W),
        .AW         (AW),
        .DESC_BYTES (DESC_BYTES)
    ) u_ring (
        .cur_idx   (idx_q),
        .ring_len  (ring_len),
        .ring_base (ring_base),
        .nxt_idx   (nxt_idx),
        .cur_addr  (cur_addr),
        .nxt_addr  (nxt_addr)
    );

    rxp_poll_timer #(
        .IVL_W (IVL_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .clear (poll_start),
        .ivl   (poll_ivl),
        .hit   (timer_hit)
    );

    rxp_protect #(
        .BC_W    (BC_W),
        .PROTECT (PROTECT)
    ) u_protect (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_cnt (byte_cnt),
        .notify   (frame_notify)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (own_cur && frame_end) begin
                    state_d = ST_WR_LAST;
                end else if (own_cur && buf_full) begin
                    state_d = ST_WR_SPILL;
                end else if (poll_go) begin
                    state_d = own_cur ? ST_RD_NXT : ST_RD_CUR;
                end
            end
            ST_RD_CUR: begin
                if (desc_ack) begin
                    state_d = (desc_rd_own && ring_len != LEN_ONE) ? ST_RD_NXT : ST_IDLE;
                end
            end
            ST_RD_NXT, ST_WR_SPILL, ST_WR_LAST: begin
                if (desc_ack) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        desc_req     = (state_q != ST_IDLE);
        desc_we      = (state_q == ST_WR_SPILL) || (state_q == ST_WR_LAST);
        desc_addr    = (state_q == ST_RD_NXT) ? nxt_addr : cur_addr;
        desc_wr_own  = 1'b0;
        desc_wr_enp  = (state_q == ST_WR_LAST);
        desc_wr_stp  = desc_we && !in_frame;
        desc_wr_bcnt = (state_q == ST_WR_LAST) ? bcnt_q : '0;
        desc_wr_err  = (state_q == ST_WR_LAST) && err_q;
    end

    assign cur_idx  = idx_q;
    assign miss_cnt = miss_q;

    // Ownership, ring index and frame tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            own_cur  <= 1'b0;
            own_nxt  <= 1'b0;
            in_frame <= 1'b0;
            dry      <= 1'b0;
            dmd_pend <= 1'b0;
            bcnt_q   <= '0;
            err_q    <= 1'b0;
            miss_q   <= '0;
        end else begin
            if (fifo_ovf && !own_cur) begin
                miss_q   <= miss_q + 1'b1;
                in_frame <= 1'b0;
            end
            if (take_last) begin
                bcnt_q <= byte_cnt;
                err_q  <= frame_err;
            end
            if (poll_demand) begin
                dmd_pend <= 1'b1;
            end
            if (poll_start || both_owned) begin
                dmd_pend <= 1'b0;
            end
            if (ack_take && state_q == ST_RD_CUR) begin
                own_cur <= desc_rd_own;
                if (!desc_rd_own) begin
                    dry <= 1'b1;
                end
            end
            if (ack_take && state_q == ST_RD_NXT) begin
                own_nxt <= desc_rd_own;
            end
            if (advance) begin
                in_frame <= (state_q == ST_WR_SPILL);
                idx_q    <= nxt_idx;
                own_cur  <= own_nxt;
                own_nxt  <= 1'b0;
            end
            if (!data_waiting) begin
                dry <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rx_desc_poller_chk.sv
module rx_desc_poller_chk #(
    parameter int IDX_W  = 4,
    parameter int AW     = 32,
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_req,
    input logic              desc_we,
    input logic              desc_ack,
    input logic [AW-1:0]     desc_addr,
    input logic              own_cur,
    input logic              own_nxt,
    input logic [IDX_W:0]    ring_len,
    input logic [IDX_W-1:0]  cur_idx,
    input logic              fifo_ovf,
    input logic [MISS_W-1:0] miss_cnt,
    input logic              frame_notify
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req && !desc_ack |=> desc_req && $stable(desc_addr) && $stable(desc_we)); // R11

    AST_OWNED_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        own_cur && (own_nxt || ring_len == 1) && !desc_req |=> !(desc_req && !desc_we)); // R2

    AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cur_idx} < ring_len); // R8

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf && !own_cur |=> miss_cnt == $past(miss_cnt) + 1'b1); // R9

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_ovf |=> $stable(miss_cnt)); // R9

    AST_NOTIFY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_notify |=> !frame_notify); // R10

    AST_WRITE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req && desc_we |-> own_cur); // R6

endmodule

bind rx_desc_poller rx_desc_poller_chk #(
    .IDX_W  (IDX_W),
    .AW     (AW),
    .MISS_W (MISS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_req     (desc_req),
    .desc_we      (desc_we),
    .desc_ack     (desc_ack),
    .desc_addr    (desc_addr),
    .own_cur      (own_cur),
    .own_nxt      (own_nxt),
    .ring_len     (ring_len),
    .cur_idx      (cur_idx),
    .fifo_ovf     (fifo_ovf),
    .miss_cnt     (miss_cnt),
    .frame_notify (frame_notify)
);

// File: tb/tb_rx_desc_poller.sv
module tb_rx_desc_poller;

    localparam int IDX_W  = 4;
    localparam int AW     = 32;
    localparam int IVL_W  = 8;
    localparam int BC_W   = 12;
    localparam int MISS_W = 8;
    localparam int IVL    = 10;
    localparam logic [AW-1:0] BASE = 32'h0000_1000;

    // Frame table: buffers per frame, error flag, expected index after the frame
    localparam int NVEC = 5;
    localparam int VEC_NBUF [NVEC] = '{1, 2, 3, 1, 2};
    localparam int VEC_ERR  [NVEC] = '{0, 1, 0, 0, 1};
    localparam int VEC_EXP  [NVEC] = '{1, 3, 2, 3, 1};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     ring_base = BASE;
    logic [IDX_W:0]    ring_len = 5'd4;
    logic [IVL_W-1:0]  poll_ivl = IVL_W'(IVL);
    logic              poll_demand = 1'b0;
    logic              data_waiting = 1'b0;
    logic              buf_full = 1'b0;
    logic              frame_end = 1'b0;
    logic              frame_err = 1'b0;
    logic [BC_W-1:0]   byte_cnt = '0;
    logic              fifo_ovf = 1'b0;
    logic              desc_req, desc_we, desc_wr_own, desc_wr_enp, desc_wr_stp, desc_wr_err;
    logic [AW-1:0]     desc_addr;
    logic [BC_W-1:0]   desc_wr_bcnt;
    logic              desc_ack = 1'b0;
    logic              desc_rd_own = 1'b0;
    logic [IDX_W-1:0]  cur_idx;
    logic              frame_notify;
    logic [MISS_W-1:0] miss_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Memory model and request log
    logic [15:0] mem_own = '0;
    bit   recycle = 1'b0;
    int   ack_lat = 0;
    int   rd_cnt = 0, wr_cnt = 0, hold_bad = 0;
    int   last_rd_cyc = 0;
    logic [AW-1:0] last_rd_addr = '0, w_addr = '0;
    logic w_own = 1'b0, w_enp = 1'b0, w_stp = 1'b0, w_err = 1'b0;
    logic [BC_W-1:0] w_bcnt = '0;

    rx_desc_poller dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ring_base    (ring_base),
        .ring_len     (ring_len),
        .poll_ivl     (poll_ivl),
        .poll_demand  (poll_demand),
        .data_waiting (data_waiting),
        .buf_full     (buf_full),
        .frame_end    (frame_end),
        .frame_err    (frame_err),
        .byte_cnt     (byte_cnt),
        .fifo_ovf     (fifo_ovf),
        .desc_req     (desc_req),
        .desc_we      (desc_we),
        .desc_addr    (desc_addr),
        .desc_wr_own  (desc_wr_own),
        .desc_wr_enp  (desc_wr_enp),
        .desc_wr_stp  (desc_wr_stp),
        .desc_wr_bcnt (desc_wr_bcnt),
        .desc_wr_err  (desc_wr_err),
        .desc_ack     (desc_ack),
        .desc_rd_own  (desc_rd_own),
        .cur_idx      (cur_idx),
        .frame_notify (frame_notify),
        .miss_cnt     (miss_cnt)
    );

    // 125 MHz clock and cycle counter
    initial forever begin
        #4 clk = ~clk;
        if (clk) cyc++;
    end

    // Descriptor responder, acts on falling edges
    initial begin
        bit busy = 1'b0;
        int wait_n = 0;
        logic [AW-1:0] h_addr = '0;
        logic h_we = 1'b0;
        forever begin
            @(negedge clk);
            if (desc_ack) begin
                desc_ack = 1'b0;
            end else if (desc_req) begin
                if (!busy) begin
                    busy = 1'b1;
                    h_addr = desc_addr;
                    h_we = desc_we;
                    wait_n = ack_lat;
                    if (!desc_we) begin
                        rd_cnt++;
                        last_rd_cyc = cyc;
                        last_rd_addr = desc_addr;
                    end
                end else if (desc_addr != h_addr || desc_we != h_we) begin
                    hold_bad++;
                end
                if (wait_n == 0) begin
                    int idx = int'((desc_addr - BASE) >> 4) & 15;
                    busy = 1'b0;
                    desc_ack = 1'b1;
                    if (desc_we) begin
                        wr_cnt++;
                        w_addr = desc_addr;
                        w_own = desc_wr_own;
                        w_enp = desc_wr_enp;
                        w_stp = desc_wr_stp;
                        w_bcnt = desc_wr_bcnt;
                        w_err = desc_wr_err;
                        mem_own[idx] = recycle;
                    end else begin
                        desc_rd_own = mem_own[idx];
                    end
                end else begin
                    wait_n--;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_rd(input string req);
        int n0 = rd_cnt;
        for (int i = 0; i < 400 && rd_cnt == n0; i++) tick(1);
        chk(req, "read start seen", int'(rd_cnt != n0), 1);
    endtask

    task automatic wait_quiet();
        int lows = 0;
        for (int i = 0; i < 500 && lows < 4; i++) begin
            tick(1);
            lows = desc_req ? 0 : lows + 1;
        end
    endtask

    task automatic wait_wr(input string req, input int n0);
        for (int i = 0; i < 400 && wr_cnt == n0; i++) tick(1);
        chk(req, "write seen", int'(wr_cnt != n0), 1);
    endtask

    task automatic pulse_demand();
        poll_demand = 1'b1;
        tick(1);
        poll_demand = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0, s0, exp_idx, w0, m0;

        // R12: reset state
        tick(4);
        chk("R12", "desc_req in reset", int'(desc_req), 0);
        chk("R12", "cur_idx in reset", int'(cur_idx), 0);
        chk("R12", "miss_cnt in reset", int'(miss_cnt), 0);
        chk("R12", "frame_notify in reset", int'(frame_notify), 0);
        rst_n = 1'b1;

        // R5: interval polls of an unowned descriptor
        wait_rd("R5");
        s0 = last_rd_cyc;
        chk("R1", "poll reads current address", int'(last_rd_addr), int'(BASE));
        wait_rd("R5");
        chk("R5", "interval poll spacing", last_rd_cyc - s0, IVL + 2);
        chk("R1", "unowned current: no next read", int'(last_rd_addr), int'(BASE));

        // R3: data waiting triggers an immediate poll, then interval
        wait_rd("R3");
        tick(3);
        n0 = rd_cnt;
        data_waiting = 1'b1;
        tick(1);
        chk("R3", "immediate poll on waiting data", rd_cnt - n0, 1);
        s0 = last_rd_cyc;
        wait_rd("R3");
        chk("R3", "dry re-poll waits for interval", last_rd_cyc - s0, IVL + 2);
        data_waiting = 1'b0;

        // R4: poll demand
        wait_rd("R4");
        tick(3);
        n0 = rd_cnt;
        pulse_demand();
        chk("R4", "demand poll next cycle", rd_cnt - n0, 1);

        // R1/R2: owning both descriptors
        tick(3);
        mem_own[0] = 1'b1;
        mem_own[1] = 1'b1;
        n0 = rd_cnt;
        pulse_demand();
        chk("R1", "current read after demand", rd_cnt - n0, 1);
        tick(2);
        chk("R1", "next read issued", rd_cnt - n0, 2);
        chk("R1", "next read address", int'(last_rd_addr), int'(BASE + 16));
        tick(3);
        m0 = int'(miss_cnt);
        fifo_ovf = 1'b1;
        tick(1);
        fifo_ovf = 1'b0;
        tick(1);
        chk("R9", "overflow while owned ignored", int'(miss_cnt), m0);
        n0 = rd_cnt;
        pulse_demand();
        tick(4 * IVL);
        chk("R2", "no reads while owning both", rd_cnt - n0, 0);

        // R6/R7/R8/R11: frame table with delayed acknowledges
        mem_own[2] = 1'b1;
        mem_own[3] = 1'b1;
        recycle = 1'b1;
        ack_lat = 2;
        data_waiting = 1'b1;
        exp_idx = 0;
        for (int v = 0; v < NVEC; v++) begin
            for (int b = 0; b < VEC_NBUF[v] - 1; b++) begin
                wait_quiet();
                w0 = wr_cnt;
                buf_full = 1'b1;
                tick(1);
                buf_full = 1'b0;
                wait_wr("R6", w0);
                chk("R6", "spill address", int'(w_addr), int'(BASE) + 16 * exp_idx);
                chk("R6", "spill OWN", int'(w_own), 0);
                chk("R6", "spill ENP", int'(w_enp), 0);
                chk("R6", "spill STP", int'(w_stp), int'(b == 0));
                exp_idx = (exp_idx + 1) % 4;
            end
            wait_quiet();
            w0 = wr_cnt;
            byte_cnt = BC_W'(100 + 7 * v);
            frame_err = (VEC_ERR[v] != 0);
            frame_end = 1'b1;
            tick(1);
            frame_end = 1'b0;
            frame_err = 1'b0;
            wait_wr("R7", w0);
            chk("R7", "last address", int'(w_addr), int'(BASE) + 16 * exp_idx);
            chk("R7", "last OWN", int'(w_own), 0);
            chk("R7", "last ENP", int'(w_enp), 1);
            chk("R7", "last STP", int'(w_stp), int'(VEC_NBUF[v] == 1));
            chk("R7", "byte count", int'(w_bcnt), 100 + 7 * v);
            chk("R7", "error flag", int'(w_err), VEC_ERR[v]);
            exp_idx = (exp_idx + 1) % 4;
            tick(1);
            chk("R8", "ring index after frame", int'(cur_idx), VEC_EXP[v]);
        end
        chk("R11", "request stable until ack", hold_bad, 0);

        // R10: protect count notification
        data_waiting = 1'b0;
        ack_lat = 0;
        byte_cnt = BC_W'(0);
        tick(2);
        byte_cnt = BC_W'(63);
        tick(2);
        chk("R10", "no notify below protect", int'(frame_notify), 0);
        byte_cnt = BC_W'(64);
        tick(1);
        chk("R10", "notify at protect", int'(frame_notify), 1);
        byte_cnt = BC_W'(90);
        tick(1);
        chk("R10", "notify single pulse", int'(frame_notify), 0);
        byte_cnt = BC_W'(0);

        // Ring length of one
        rst_n = 1'b0;
        recycle = 1'b0;
        ring_len = 5'd1;
        mem_own = '0;
        mem_own[0] = 1'b1;
        tick(3);
        chk("R12", "miss_cnt cleared by reset", int'(miss_cnt), 0);
        n0 = rd_cnt;
        rst_n = 1'b1;
        tick(IVL + 15);
        chk("R1", "length one reads current only", rd_cnt - n0, 1);
        chk("R1", "length one read address", int'(last_rd_addr), int'(BASE));
        tick(4 * IVL);
        chk("R2", "length one owned: no reads", rd_cnt - n0, 1);
        w0 = wr_cnt;
        byte_cnt = BC_W'(77);
        frame_end = 1'b1;
        tick(1);
        frame_end = 1'b0;
        wait_wr("R7", w0);
        chk("R7", "length one STP", int'(w_stp), 1);
        chk("R8", "length one write address", int'(w_addr), int'(BASE));
        tick(1);
        chk("R8", "length one index wraps", int'(cur_idx), 0);

        // R9: overflow without a descriptor
        wait_quiet();
        fifo_ovf = 1'b1;
        tick(1);
        fifo_ovf = 1'b0;
        chk("R9", "miss count increments", int'(miss_cnt), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule